// File: doc/BRIEF.md
# Clocked Serial Slave Receiver

This block is the receive side of a clocked serial port whose bit clock is driven by an external master. Data bits arrive on a data pin and are clocked in by the master's clock pin. Both pins are resynchronised into the system clock domain, so every register in the block runs on one clock. Bits are collected least significant first in a shift register. When a word is complete, it moves into a holding register that the host can read.

A small register file configures and observes the block. It holds the enables, the word length (8 or 9 bits), the received ninth bit, an overrun flag, a receive-complete flag and its interrupt enable. The flag and enable together drive an interrupt request. Reception carries on while the host core is asleep, and a completed word with its interrupt enabled raises a wake request. An overrun is recovered by turning the continuous-receive enable off and on again, not by reading the data.

Top module: `ssr_slave_rx`

## Requirements
- R1: Words are received only when the mode register has sync bit (addr 1, bit 0) = 1 and clock-source bit (addr 1, bit 1) = 0, and the control register (addr 0) has port enable (bit 7) = 1 and continuous enable (bit 4) = 1. Otherwise clock edges leave the data register and the flag unchanged.
- R2: The single-receive bit (addr 0, bit 5) has no effect: it neither starts nor stops reception.
- R3: Data is sampled on falling edges of the serial clock, least significant bit first. After 8 falling edges (or 9 in 9-bit mode), the low 8 bits appear in the data register (addr 2) and the receive flag (addr 3, bit 0) is set.
- R4: The interrupt output is 1 exactly when the receive flag and the interrupt enable (addr 3, bit 1) are both 1.
- R5: With the 9-bit select (addr 0, bit 6) = 1, the ninth received bit reads at addr 0 bit 0. In 8-bit mode that bit reads 0.
- R6: If a word completes while the receive flag is still set, the overrun bit (addr 0, bit 1) is set and the data register keeps its old value. No further word is accepted until the overrun is cleared.
- R7: Writing continuous enable = 0 clears the overrun bit and discards any partially received word. Bit 2 of addr 0 always reads 0.
- R8: A read strobe at addr 2 clears the receive flag.
- R9: Reception continues while the sleep input is high. The wake output is 1 when sleep, the receive flag and the interrupt enable are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial bit clock from the external master |
| serData | input | 1 | Serial data line |
| coreSleep | input | 1 | High while the host core sleeps |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect at addr 2) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational from addr) |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request to the sleeping core |

## Verification
A falling serial clock edge reaches the shift logic on the third rising system clock edge after the pin changes. This is two synchroniser stages plus the edge-detect flop. The data register, flag, ninth bit and overrun bit therefore update on that third edge, and irq and wake follow in the same cycle. The bench holds each serial clock phase for eight system cycles and samples outputs on falling system clock edges only after the final phase has elapsed. Register writes take effect at the next rising edge and are checked half a cycle later. Read-data values are combinational and are sampled mid-cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef logic [1:0] regAddr_t;

  localparam regAddr_t ADDR_CTRL = 2'd0;
  localparam regAddr_t ADDR_MODE = 2'd1;
  localparam regAddr_t ADDR_DATA = 2'd2;
  localparam regAddr_t ADDR_INTR = 2'd3;

  localparam int CB_PORT_EN = 7;
  localparam int CB_NINE    = 6;
  localparam int CB_SINGLE  = 5;
  localparam int CB_CONT    = 4;
  localparam int CB_FRAME   = 2;
  localparam int CB_OVR     = 1;
  localparam int CB_NINTH   = 0;
  localparam int MB_SYNC    = 0;
  localparam int MB_CLKSRC  = 1;
  localparam int IB_FLAG    = 0;
  localparam int IB_EN      = 1;

  typedef struct packed {
    logic shiftEn;
    logic clrPartial;
    logic loadHold;
  } rxStrobes_t;
endpackage

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              nineSel,
  input  rxStrobes_t        strb,
  output logic              wordDone,
  output logic [DATA_W-1:0] holdData,
  output logic              holdNinth
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] datSync;
  logic                   clkPrev;
  logic                   fallEvt;
  logic                   datBit;
  logic [CNT_W-1:0]       bitCnt;
  logic [CNT_W-1:0]       lastIdx;
  logic [WORD_W-1:0]      shReg;
  logic [WORD_W-1:0]      fullWord;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync <= '0;
          datSync <= '0;
        end else begin
          clkSync <= serClk;
          datSync <= serData;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync <= '0;
          datSync <= '0;
        end else begin
          clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
          datSync <= {datSync[SYNC_STAGES-2:0], serData};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkSync[SYNC_STAGES-1];
  end

  assign fallEvt  = clkPrev & ~clkSync[SYNC_STAGES-1];
  assign datBit   = datSync[SYNC_STAGES-1];
  assign lastIdx  = nineSel ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign wordDone = fallEvt & strb.shiftEn & (bitCnt == lastIdx);

  always_comb begin
    fullWord         = shReg;
    fullWord[bitCnt] = datBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrPartial) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (fallEvt && strb.shiftEn) begin
      if (wordDone) begin
        bitCnt <= '0;
        shReg  <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
        shReg  <= fullWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdNinth <= 1'b0;
    end else if (strb.loadHold) begin
      holdData  <= fullWord[DATA_W-1:0];
      holdNinth <= nineSel & fullWord[DATA_W];
    end
  end
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreSleep,
  input  logic              wrEn,
  input  logic              rdEn,
  input  regAddr_t          addr,
  input  logic [7:0]        wrData,
  input  logic              wordDone,
  input  logic [DATA_W-1:0] holdData,
  input  logic              holdNinth,
  output logic [7:0]        rdData,
  output rxStrobes_t        strb,
  output logic              nineSel,
  output logic              active,
  output logic              contEn,
  output logic              rxFlag,
  output logic              overrun,
  output logic              irq,
  output logic              wake
);
  logic portEn, singleRx, syncMode, clkSrc, intEn;
  logic unusedBits;

  assign unusedBits = ^{wrData[3:2], wrData[7:2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portEn   <= 1'b0;
      nineSel  <= 1'b0;
      singleRx <= 1'b0;
      contEn   <= 1'b0;
      syncMode <= 1'b0;
      clkSrc   <= 1'b0;
      intEn    <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        ADDR_CTRL: begin
          portEn   <= wrData[CB_PORT_EN];
          nineSel  <= wrData[CB_NINE];
          singleRx <= wrData[CB_SINGLE];
          contEn   <= wrData[CB_CONT];
        end
        ADDR_MODE: begin
          syncMode <= wrData[MB_SYNC];
          clkSrc   <= wrData[MB_CLKSRC];
        end
        ADDR_INTR: intEn <= wrData[IB_EN];
        default: ;
      endcase
    end
  end

  assign active          = syncMode & portEn & ~clkSrc & contEn;
  assign strb.shiftEn    = active & ~overrun;
  assign strb.clrPartial = ~active;
  assign strb.loadHold   = wordDone & ~rxFlag;

  always_ff @(posedge clk) begin
    if (!rstN)                            rxFlag <= 1'b0;
    else if (strb.loadHold)               rxFlag <= 1'b1;
    else if (rdEn && addr == ADDR_DATA)   rxFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !contEn)          overrun <= 1'b0;
    else if (wordDone && rxFlag)   overrun <= 1'b1;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[CB_PORT_EN] = portEn;
        rdData[CB_NINE]    = nineSel;
        rdData[CB_SINGLE]  = singleRx;
        rdData[CB_CONT]    = contEn;
        rdData[CB_FRAME]   = 1'b0;
        rdData[CB_OVR]     = overrun;
        rdData[CB_NINTH]   = holdNinth;
      end
      ADDR_MODE: begin
        rdData[MB_SYNC]   = syncMode;
        rdData[MB_CLKSRC] = clkSrc;
      end
      ADDR_DATA: rdData = 8'(holdData);
      default: begin
        rdData[IB_FLAG] = rxFlag;
        rdData[IB_EN]   = intEn;
      end
    endcase
  end

  assign irq  = rxFlag & intEn;
  assign wake = coreSleep & irq;
endmodule

// File: rtl/ssr_slave_rx.sv
module ssr_slave_rx
  import ssr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       coreSleep,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       wake
);
  rxStrobes_t        strb;
  logic              wordDone;
  logic [DATA_W-1:0] holdData;
  logic              holdNinth;
  logic              nineSel;
  logic              active;
  logic              contEn;
  logic              rxFlag;
  logic              overrun;

  ssr_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .nineSel(nineSel), .strb(strb), .wordDone(wordDone),
    .holdData(holdData), .holdNinth(holdNinth)
  );

  ssr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .coreSleep(coreSleep), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .wordDone(wordDone), .holdData(holdData),
    .holdNinth(holdNinth), .rdData(rdData), .strb(strb), .nineSel(nineSel),
    .active(active), .contEn(contEn), .rxFlag(rxFlag), .overrun(overrun),
    .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              active,
  input logic              contEn,
  input logic              overrun,
  input logic              rxFlag,
  input logic              rdEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] holdData,
  input logic              irq,
  input logic              coreSleep,
  input logic              wake
);
  AST_INACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> $stable(holdData)); // R1
  AST_FLAG_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(active)); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rxFlag); // R4
  AST_OVR_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> $stable(holdData)); // R6
  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !contEn |=> !overrun); // R7
  AST_FLAG_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFlag) |-> $past(rdEn && addr == 2'd2)); // R8
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> (coreSleep && irq)); // R9
endmodule

bind ssr_slave_rx ssr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .active(active), .contEn(contEn),
  .overrun(overrun), .rxFlag(rxFlag), .rdEn(rdEn), .addr(addr),
  .holdData(holdData), .irq(irq), .coreSleep(coreSleep), .wake(wake)
);

// File: tb/tb_ssr_slave_rx.sv
`timescale 1ns/1ps
module tb_ssr_slave_rx;
  localparam int HALF = 8;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic coreSleep = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irq, wake;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ssr_slave_rx dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .coreSleep(coreSleep), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wake(wake)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !finished) begin
      fails++;
      $display("FAIL R0 watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] expData(logic [8:0] w);
    return w[7:0];
  endfunction

  function automatic logic expNinth(logic [8:0] w, bit nine);
    return nine ? w[8] : 1'b0;
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regPeek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1 d = rdData;
  endtask

  task automatic readData(output logic [7:0] d);
    @(negedge clk);
    addr = 2'd2; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic sendBits(logic [8:0] w, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      serData = w[i];
      repeat (HALF) @(negedge clk);
      serClk = 1'b0;
      repeat (HALF) @(negedge clk);
      serClk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [8:0] w;
    logic [8:0] held;
    bit nine;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    regPeek(2'd0, v); check("R1 reset ctrl", 9'(v), 9'h000);
    regPeek(2'd3, v); check("R4 reset intr", 9'(v), 9'h000);
    check("R4 reset irq", 9'(irq), 9'h0);

    // R1: not configured, nothing received
    regWrite(2'd0, 8'h90);
    sendBits(9'h0A5, 8);
    regPeek(2'd3, v); check("R1 sync off no flag", 9'(v[0]), 9'h0);
    regWrite(2'd1, 8'h03);
    sendBits(9'h05A, 8);
    regPeek(2'd3, v); check("R1 internal clock no flag", 9'(v[0]), 9'h0);
    regPeek(2'd2, v); check("R1 data unchanged", 9'(v), 9'h000);
    regWrite(2'd1, 8'h01);

    // R2: single-receive bit does not start reception
    regWrite(2'd0, 8'hA0);
    sendBits(9'h033, 8);
    regPeek(2'd3, v); check("R2 single bit alone no flag", 9'(v[0]), 9'h0);
    regWrite(2'd0, 8'hB0);
    sendBits(9'h0C3, 8);
    readData(v); check("R2 single bit set still receives", 9'(v), 9'h0C3);

    // R3, R8: basic 8-bit word and read clear
    regWrite(2'd0, 8'h90);
    sendBits(9'h1B7, 8);
    regPeek(2'd3, v); check("R3 flag set", 9'(v[0]), 9'h1);
    regPeek(2'd0, v); check("R5 ninth zero 8-bit", 9'(v[0]), 9'h0);
    check("R7 frame bit zero", 9'(v[2]), 9'h0);
    readData(v); check("R3 data lsb first", 9'(v), 9'h0B7);
    regPeek(2'd3, v); check("R8 flag cleared by read", 9'(v[0]), 9'h0);

    // R4: interrupt gating
    sendBits(9'h011, 8);
    check("R4 irq off when disabled", 9'(irq), 9'h0);
    regWrite(2'd3, 8'h02);
    check("R4 irq on when enabled", 9'(irq), 9'h1);
    readData(v);
    check("R4 irq drops after read", 9'(irq), 9'h0);

    // R5: 9-bit mode
    regWrite(2'd0, 8'hD0);
    sendBits(9'h155, 9);
    regPeek(2'd0, v); check("R5 ninth bit one", 9'(v[0]), 9'h1);
    readData(v); check("R5 low byte", 9'(v), 9'h055);
    sendBits(9'h0AA, 9);
    regPeek(2'd0, v); check("R5 ninth bit zero", 9'(v[0]), 9'h0);
    readData(v); check("R5 low byte 2", 9'(v), 9'h0AA);

    // R6: overrun
    regWrite(2'd0, 8'h90);
    sendBits(9'h012, 8);
    sendBits(9'h034, 8);
    regPeek(2'd0, v); check("R6 overrun set", 9'(v[1]), 9'h1);
    regPeek(2'd2, v); check("R6 data kept", 9'(v), 9'h012);
    sendBits(9'h056, 8);
    regPeek(2'd2, v); check("R6 blocked while overrun", 9'(v), 9'h012);

    // R7: clear by dropping continuous enable
    regWrite(2'd0, 8'h80);
    regPeek(2'd0, v); check("R7 overrun cleared", 9'(v[1]), 9'h0);
    regWrite(2'd0, 8'h90);
    readData(v); check("R6 old data readable", 9'(v), 9'h012);
    sendBits(9'h0F0, 3);
    regWrite(2'd0, 8'h80);
    regWrite(2'd0, 8'h90);
    sendBits(9'h069, 8);
    readData(v); check("R7 partial discarded", 9'(v), 9'h069);

    // R9: reception and wake during sleep
    coreSleep = 1'b1;
    check("R9 no wake without word", 9'(wake), 9'h0);
    sendBits(9'h0E1, 8);
    check("R9 wake asserted", 9'(wake), 9'h1);
    readData(v); check("R9 data received asleep", 9'(v), 9'h0E1);
    check("R9 wake released", 9'(wake), 9'h0);
    coreSleep = 1'b0;

    // Random words, mixed lengths
    for (int k = 0; k < 24; k++) begin
      w = 9'($urandom);
      nine = $urandom_range(0, 1) == 1;
      regWrite(2'd0, nine ? 8'hD0 : 8'h90);
      sendBits(w, nine ? 9 : 8);
      regPeek(2'd0, v); check("R5 random ninth", 9'(v[0]), 9'(expNinth(w, nine)));
      readData(v); check("R3 random data", 9'(v), 9'(expData(w)));
      held = 9'(v);
    end
    check("R3 last random held", held, 9'(expData(w)));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule